// File: doc/BRIEF.md
# Interrupt Context Stacking and Return Sequencer

This block saves a processor's context into a byte-wide stack memory when an interrupt is taken, and brings it back when the handler returns. A one-cycle entry strobe makes the block capture the current program counter, accumulator, low byte of the index register and condition code byte. It then writes them as a five-byte frame below the current stack pointer, with one write per clock. The upper byte of the index register is not part of the frame. Software must save it itself if the handler changes it.

A one-cycle return strobe makes the block read the frame back in the opposite order and place the recovered values on its restore outputs. It then reads three program bytes, starting at the recovered program counter, so the fetch pipeline can refill. Each of those bytes is shown on a fetch output with a valid strobe. The memory port is synchronous: a read issued in one cycle returns its data in the next cycle.

The sequencer has six states: `ST_IDLE`, `ST_PUSH`, `ST_PULL`, `ST_SETTLE`, `ST_FETCH` and `ST_FLUSH`. Its transitions are:
- `ST_IDLE` to `ST_PUSH` when the entry strobe is seen.
- `ST_IDLE` to `ST_PULL` when the return strobe is seen and the entry strobe is not.
- `ST_PUSH` to `ST_IDLE` after the fifth write.
- `ST_PULL` to `ST_SETTLE` after the fifth read.
- `ST_SETTLE` to `ST_FETCH` after one cycle with no access, while the last frame byte is returned.
- `ST_FETCH` to `ST_FLUSH` after the third program read.
- `ST_FLUSH` to `ST_IDLE` once the last program byte has been returned.

Top module: `isf_seq`

## Requirements
- R1: On entry, the five frame writes go to addresses SP, SP-1, SP-2, SP-3 and SP-4, where SP is `cur_sp` at the strobe. They carry, in that order, PC bits 7:0, PC bits 15:8, index low byte, accumulator and condition code byte. The stack pointer drops by one after each write.
- R2: Stacking makes exactly five writes and no other memory access. Nothing is written at SP-5 or below, so the index high byte is never stored.
- R3: After stacking, `sp_out` equals the entry SP minus 5, modulo 2^16.
- R4: On return, the five frame reads go to addresses SP+1 through SP+5, where SP is `cur_sp` at the strobe. The stack pointer rises by one before each read. The bytes read are loaded, in that order, into `ret_ccr`, `ret_acc`, `ret_xl`, PC bits 15:8 and PC bits 7:0. At the end, `sp_out` equals the return SP plus 5.
- R5: After the frame reads, three program reads go to the restored PC, PC+1 and PC+2, wrapping modulo 2^16. Each byte appears on `fetch_data`, with `fetch_valid` high, in the cycle after its read.
- R6: At most one memory access is made per clock. `busy` is high from the cycle after an accepted strobe until the last data has been returned: 5 cycles for stacking and 10 cycles for a return.
- R7: `done` is a one-cycle pulse in the first cycle after `busy` falls. That is 6 cycles after the entry strobe is sampled, or 11 cycles after the return strobe is sampled.
- R8: A strobe sampled while `busy` is high is ignored. The running sequence keeps its access count and timing, and no new sequence starts afterwards.
- R9: If both strobes are sampled together while idle, stacking takes place and the return request is dropped.
- R10: While reset is held, `busy`, `done`, `mem_req`, `fetch_valid` and `sp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| irq_start | input | 1 | Entry strobe: stack the context |
| rti_start | input | 1 | Return strobe: unstack the frame and refill |
| cur_pc | input | 16 | Program counter to save |
| cur_acc | input | 8 | Accumulator to save |
| cur_xl | input | 8 | Index register low byte to save |
| cur_ccr | input | 8 | Condition code byte to save |
| cur_sp | input | 16 | Stack pointer at the strobe |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Working stack pointer |
| ret_pc | output | 16 | Restored program counter |
| ret_acc | output | 8 | Restored accumulator |
| ret_xl | output | 8 | Restored index low byte |
| ret_ccr | output | 8 | Restored condition code byte |
| fetch_valid | output | 1 | A refill byte is on fetch_data |
| fetch_data | output | 8 | Refill byte |

## Verification
The cycles below are counted from the clock edge that samples the strobe:
- `busy` is due in cycle 1.
- A stacking write is due in each of cycles 1 to 5, and `done` in cycle 6.
- On return, a frame read is due in each of cycles 1 to 5, and cycle 6 carries no access.
- The program reads are due in cycles 7 to 9, their bytes on `fetch_data` in cycles 8 to 10, and `done` in cycle 11.

The bench drives its strobes and samples the outputs on the falling edge. It counts cycles from that strobe until `done` and compares the count with 6 or 11. It logs every memory access and every fetch byte at the falling edge, when the combinational outputs are stable, and compares that log with the addresses and bytes the requirements predict. The test for ignored strobes waits four further idle cycles and confirms that no access has appeared.

// File: rtl/isf_pkg.sv
package isf_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL,
        ST_SETTLE,
        ST_FETCH,
        ST_FLUSH
    } isf_state_e;

    // Kind of read that is outstanding, so the returning byte can be routed.
    typedef enum logic [1:0] {
        TAG_NONE,
        TAG_POP,
        TAG_FETCH
    } isf_tag_e;

    // Number of bytes in one frame.
    localparam int unsigned FRAME_LEN = 5;

    // Slot codes in write order. A read takes slot FRAME_LEN-1-k at step k.
    localparam logic [2:0] SLOT_PCL = 3'd0;
    localparam logic [2:0] SLOT_PCH = 3'd1;
    localparam logic [2:0] SLOT_XL  = 3'd2;
    localparam logic [2:0] SLOT_ACC = 3'd3;
    localparam logic [2:0] SLOT_CCR = 3'd4;

endpackage

// File: rtl/isf_push_mux.sv
module isf_push_mux
    import isf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] pc,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   xl,
    input  logic [DW-1:0]   ccr,
    input  logic [2:0]      slot,
    output logic [DW-1:0]   byte_out
);

    // Choose the context byte that belongs in the given frame slot.
    always_comb begin
        case (slot)
            SLOT_PCL: byte_out = pc[DW-1:0];
            SLOT_PCH: byte_out = pc[2*DW-1:DW];
            SLOT_XL:  byte_out = xl;
            SLOT_ACC: byte_out = acc;
            SLOT_CCR: byte_out = ccr;
            default:  byte_out = '0;
        endcase
    end

endmodule

// File: rtl/isf_sp_unit.sv
module isf_sp_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_down,
    input  logic          step_up,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_plus1
);

    logic [AW-1:0] sp_q;

    // Working stack pointer. Load has priority over the two step inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_val;
        end else if (step_down) begin
            sp_q <= sp_q - AW'(1);
        end else if (step_up) begin
            sp_q <= sp_q + AW'(1);
        end
    end

    assign sp       = sp_q;
    assign sp_plus1 = sp_q + AW'(1);

endmodule

// File: rtl/isf_restore_bank.sv
module isf_restore_bank
    import isf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [2:0]      slot,
    input  logic [DW-1:0]   data,
    output logic [2*DW-1:0] pc,
    output logic [DW-1:0]   acc,
    output logic [DW-1:0]   xl,
    output logic [DW-1:0]   ccr
);

    logic [DW-1:0] pcl_q, pch_q, acc_q, xl_q, ccr_q;

    // Load each returning frame byte into the register for its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcl_q <= '0;
            pch_q <= '0;
            acc_q <= '0;
            xl_q  <= '0;
            ccr_q <= '0;
        end else if (cap_en) begin
            case (slot)
                SLOT_PCL: pcl_q <= data;
                SLOT_PCH: pch_q <= data;
                SLOT_XL:  xl_q  <= data;
                SLOT_ACC: acc_q <= data;
                SLOT_CCR: ccr_q <= data;
                default:  ;
            endcase
        end
    end

    assign pc  = {pch_q, pcl_q};
    assign acc = acc_q;
    assign xl  = xl_q;
    assign ccr = ccr_q;

endmodule

// File: rtl/isf_seq.sv
module isf_seq
    import isf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int REFILL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_start,
    input  logic              rti_start,
    input  logic [2*DW-1:0]   cur_pc,
    input  logic [DW-1:0]     cur_acc,
    input  logic [DW-1:0]     cur_xl,
    input  logic [DW-1:0]     cur_ccr,
    input  logic [2*DW-1:0]   cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [2*DW-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [2*DW-1:0]   sp_out,
    output logic [2*DW-1:0]   ret_pc,
    output logic [DW-1:0]     ret_acc,
    output logic [DW-1:0]     ret_xl,
    output logic [DW-1:0]     ret_ccr,
    output logic              fetch_valid,
    output logic [DW-1:0]     fetch_data
);

    localparam int AW      = 2 * DW;
    localparam int MAX_CNT = (int'(FRAME_LEN) > REFILL) ? int'(FRAME_LEN) : REFILL;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    isf_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    isf_tag_e          tag_q, tag_d;
    logic [2:0]        tag_slot_q, tag_slot_d;
    logic              done_q, done_d;

    logic [AW-1:0]     snap_pc;
    logic [DW-1:0]     snap_acc, snap_xl, snap_ccr;

    logic              go_irq, go_rti;
    logic              push_last, pull_last, fetch_last;
    logic [2:0]        push_slot, pull_slot;
    logic [DW-1:0]     push_byte;
    logic [AW-1:0]     sp_now, sp_next_up;

    // Strobe decode. Strobes count only in idle, and entry beats return.
    assign go_irq = (state_q == ST_IDLE) && irq_start;
    assign go_rti = (state_q == ST_IDLE) && !irq_start && rti_start;

    assign push_last  = (cnt_q == CNT_W'(FRAME_LEN - 1));
    assign pull_last  = push_last;
    assign fetch_last = (cnt_q == CNT_W'(REFILL - 1));
    assign push_slot  = 3'(cnt_q);
    assign pull_slot  = 3'(CNT_W'(FRAME_LEN - 1) - cnt_q);

    isf_sp_unit #(.AW(AW)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go_irq || go_rti),
        .load_val  (cur_sp),
        .step_down (state_q == ST_PUSH),
        .step_up   (state_q == ST_PULL),
        .sp        (sp_now),
        .sp_plus1  (sp_next_up)
    );

    isf_push_mux #(.DW(DW)) u_mux (
        .pc       (snap_pc),
        .acc      (snap_acc),
        .xl       (snap_xl),
        .ccr      (snap_ccr),
        .slot     (push_slot),
        .byte_out (push_byte)
    );

    isf_restore_bank #(.DW(DW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (tag_q == TAG_POP),
        .slot   (tag_slot_q),
        .data   (mem_rdata),
        .pc     (ret_pc),
        .acc    (ret_acc),
        .xl     (ret_xl),
        .ccr    (ret_ccr)
    );

    // Next state and step counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (go_irq)      state_d = ST_PUSH;
                else if (go_rti) state_d = ST_PULL;
            end
            ST_PUSH: begin
                if (push_last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_PULL: begin
                if (pull_last) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_SETTLE: begin
                state_d = ST_FETCH;
                cnt_d   = '0;
            end
            ST_FETCH: begin
                if (fetch_last) begin
                    state_d = ST_FLUSH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_FLUSH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Memory port, read tag and completion, all decoded from the state.
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tag_d      = TAG_NONE;
        tag_slot_d = '0;
        done_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_now;
                mem_wdata = push_byte;
                done_d    = push_last;
            end
            ST_PULL: begin
                mem_req    = 1'b1;
                mem_addr   = sp_next_up;
                tag_d      = TAG_POP;
                tag_slot_d = pull_slot;
            end
            ST_SETTLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ret_pc + AW'(cnt_q);
                tag_d    = TAG_FETCH;
            end
            ST_FLUSH: begin
                done_d = 1'b1;
            end
            default: ;
        endcase
    end

    // State register and captured context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            tag_q      <= TAG_NONE;
            tag_slot_q <= '0;
            done_q     <= 1'b0;
            snap_pc    <= '0;
            snap_acc   <= '0;
            snap_xl    <= '0;
            snap_ccr   <= '0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            tag_q      <= tag_d;
            tag_slot_q <= tag_slot_d;
            done_q     <= done_d;
            if (go_irq) begin
                snap_pc  <= cur_pc;
                snap_acc <= cur_acc;
                snap_xl  <= cur_xl;
                snap_ccr <= cur_ccr;
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign sp_out      = sp_now;
    assign fetch_valid = (tag_q == TAG_FETCH);
    assign fetch_data  = fetch_valid ? mem_rdata : '0;

endmodule

// File: rtl/isf_seq_chk.sv
module isf_seq_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_start,
    input logic            rti_start,
    input logic            mem_req,
    input logic            mem_we,
    input logic [2*DW-1:0] mem_addr,
    input logic            busy,
    input logic            done,
    input logic [2*DW-1:0] sp_out,
    input logic            fetch_valid
);

    // R1: each frame write goes to the working SP.
    a_r1_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == sp_out));

    // R1: SP drops by one after each frame write.
    a_r1_sp_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp_out == $past(sp_out) - 1'b1));

    // R6: accesses happen only while busy.
    a_r6_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: refill bytes appear only inside a sequence.
    a_r5_fetch_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> busy);

    // R7: done lasts a single cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows the fall of busy.
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: busy rises only because of a strobe.
    a_r8_start_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(irq_start || rti_start));

    // R9: an entry strobe in idle always starts with a write.
    a_r9_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_start && !busy) |=> (mem_req && mem_we));

endmodule

bind isf_seq isf_seq_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_start   (irq_start),
    .rti_start   (rti_start),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .done        (done),
    .sp_out      (sp_out),
    .fetch_valid (fetch_valid)
);

// File: tb/isf_seq_tb.sv
module isf_seq_tb;

    localparam int DW = 8;
    localparam int AW = 16;
    localparam int NV = 4;

    // Each vector is {pc[55:40], acc[39:32], xl[31:24], ccr[23:16], sp[15:0]}.
    localparam logic [55:0] VEC [NV] = '{
        {16'h1240, 8'h5A, 8'h3C, 8'hE1, 16'h00F0},
        {16'h80FE, 8'hA5, 8'h0F, 8'h02, 16'h0050},
        {16'hC003, 8'h00, 8'hFF, 8'h7F, 16'h0102},
        {16'hFFFF, 8'h81, 8'h18, 8'hC8, 16'h2090}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, irq_start, rti_start;
    logic [AW-1:0] cur_pc, cur_sp;
    logic [DW-1:0] cur_acc, cur_xl, cur_ccr;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fetch_valid;
    logic [AW-1:0] sp_out, ret_pc;
    logic [DW-1:0] ret_acc, ret_xl, ret_ccr, fetch_data;

    isf_seq #(.DW(DW), .REFILL(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_start(irq_start), .rti_start(rti_start),
        .cur_pc(cur_pc), .cur_acc(cur_acc), .cur_xl(cur_xl), .cur_ccr(cur_ccr),
        .cur_sp(cur_sp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .sp_out(sp_out), .ret_pc(ret_pc), .ret_acc(ret_acc), .ret_xl(ret_xl),
        .ret_ccr(ret_ccr), .fetch_valid(fetch_valid), .fetch_data(fetch_data)
    );

    // Synchronous byte memory: one 256-byte page, indexed by the address low byte.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    end

    // Access and fetch logs, sampled at the falling edge.
    int         log_n = 0;
    logic       lg_we   [256];
    logic [15:0] lg_addr [256];
    logic [7:0] lg_wd   [256];
    int         fl_n = 0;
    logic [7:0] fl_d [256];

    always @(negedge clk) begin
        if (mem_req) begin
            lg_we[log_n % 256]   = mem_we;
            lg_addr[log_n % 256] = mem_addr;
            lg_wd[log_n % 256]   = mem_wdata;
            log_n++;
        end
        if (fetch_valid) begin
            fl_d[fl_n % 256] = fetch_data;
            fl_n++;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input logic [55:0] v, input int i);
        case (i)
            0: return v[47:40];
            1: return v[55:48];
            2: return v[31:24];
            3: return v[39:32];
            default: return v[23:16];
        endcase
    endfunction

    function automatic logic [7:0] prog_byte(input logic [15:0] pc, input int i);
        return pc[7:0] ^ (8'h5C + 8'(i));
    endfunction

    task automatic preload(input logic [55:0] v);
        for (int i = 0; i < 3; i++) begin
            logic [15:0] a;
            a = v[55:40] + 16'(i);
            mem[a[7:0]] = prog_byte(v[55:40], i);
        end
    endtask

    // Start a sequence; poke both strobes for one cycle at cycle poke_cyc (0 = never).
    task automatic run(input bit irq, input bit rti, input logic [55:0] v,
                       input int poke_cyc, output int cyc, output int lbase, output int fbase);
        @(negedge clk);
        cur_pc = v[55:40]; cur_acc = v[39:32]; cur_xl = v[31:24];
        cur_ccr = v[23:16]; cur_sp = v[15:0];
        irq_start = irq; rti_start = rti;
        lbase = log_n; fbase = fl_n;
        @(negedge clk);
        irq_start = 1'b0; rti_start = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R6", "busy in cycle 1", 32'(busy), 1);
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
            irq_start = (cyc == poke_cyc);
            rti_start = (cyc == poke_cyc);
        end
        irq_start = 1'b0; rti_start = 1'b0;
        chk(busy == 1'b0, "R6", "busy low at done", 32'(busy), 0);
    endtask

    task automatic check_push(input logic [55:0] v, input int cyc, input int lbase);
        logic [15:0] sp;
        sp = v[15:0];
        chk(cyc == 6, "R7", "stack done cycle", 32'(cyc), 6);
        chk(log_n - lbase == 5, "R2", "stack access count", 32'(log_n - lbase), 5);
        for (int i = 0; i < 5; i++) begin
            int k;
            k = (lbase + i) % 256;
            chk(lg_we[k] == 1'b1, "R2", "stack access is write", 32'(lg_we[k]), 1);
            chk(lg_addr[k] == sp - 16'(i), "R1", "stack write address",
                32'(lg_addr[k]), 32'(sp - 16'(i)));
            chk(lg_wd[k] == frame_byte(v, i), "R1", "stack write byte",
                32'(lg_wd[k]), 32'(frame_byte(v, i)));
        end
        chk(sp_out == sp - 16'd5, "R3", "sp after stacking", 32'(sp_out), 32'(sp - 16'd5));
    endtask

    task automatic check_pull(input logic [55:0] v, input int cyc, input int lbase, input int fbase);
        logic [15:0] sp, pc;
        sp = v[15:0];
        pc = v[55:40];
        chk(cyc == 11, "R7", "return done cycle", 32'(cyc), 11);
        chk(log_n - lbase == 8, "R6", "return access count", 32'(log_n - lbase), 8);
        for (int i = 0; i < 5; i++) begin
            int k;
            k = (lbase + i) % 256;
            chk(lg_we[k] == 1'b0, "R4", "frame access is read", 32'(lg_we[k]), 0);
            chk(lg_addr[k] == sp - 16'd4 + 16'(i), "R4", "frame read address",
                32'(lg_addr[k]), 32'(sp - 16'd4 + 16'(i)));
        end
        for (int i = 0; i < 3; i++) begin
            int k;
            k = (lbase + 5 + i) % 256;
            chk(lg_addr[k] == pc + 16'(i) && !lg_we[k], "R5", "refill read address",
                32'(lg_addr[k]), 32'(pc + 16'(i)));
            chk(fl_d[(fbase + i) % 256] == prog_byte(pc, i), "R5", "refill byte",
                32'(fl_d[(fbase + i) % 256]), 32'(prog_byte(pc, i)));
        end
        chk(fl_n - fbase == 3, "R5", "refill byte count", 32'(fl_n - fbase), 3);
        chk(ret_pc == pc, "R4", "restored pc", 32'(ret_pc), 32'(pc));
        chk(ret_acc == v[39:32], "R4", "restored acc", 32'(ret_acc), 32'(v[39:32]));
        chk(ret_xl == v[31:24], "R4", "restored xl", 32'(ret_xl), 32'(v[31:24]));
        chk(ret_ccr == v[23:16], "R4", "restored ccr", 32'(ret_ccr), 32'(v[23:16]));
        chk(sp_out == sp, "R4", "sp after return", 32'(sp_out), 32'(sp));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc, lb, fb, lsave;
        logic [55:0] rv;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; irq_start = 1'b0; rti_start = 1'b0;
        cur_pc = '0; cur_acc = '0; cur_xl = '0; cur_ccr = '0; cur_sp = '0;
        repeat (3) @(negedge clk);
        // R10: state while reset is held.
        chk(busy == 0 && done == 0, "R10", "busy/done in reset", 32'({busy, done}), 0);
        chk(mem_req == 0 && fetch_valid == 0, "R10", "req/fetch in reset",
            32'({mem_req, fetch_valid}), 0);
        chk(sp_out == 16'h0, "R10", "sp in reset", 32'(sp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: stack, then return, for each entry.
        for (int n = 0; n < NV; n++) begin
            run(1'b1, 1'b0, VEC[n], 0, cyc, lb, fb);
            check_push(VEC[n], cyc, lb);
            preload(VEC[n]);
            rv = {40'h0, VEC[n][15:0] - 16'd5};
            run(1'b0, 1'b1, rv, 0, cyc, lb, fb);
            check_pull(VEC[n], cyc, lb, fb);
        end

        // R8: both strobes poked in cycle 3 of stacking are ignored.
        run(1'b1, 1'b0, VEC[0], 3, cyc, lb, fb);
        check_push(VEC[0], cyc, lb);
        lsave = log_n;
        repeat (4) @(negedge clk);
        chk(log_n == lsave, "R8", "no access after ignored strobe", 32'(log_n - lsave), 0);
        chk(busy == 1'b0, "R8", "idle after ignored strobe", 32'(busy), 0);

        // R9: both strobes together in idle lead to stacking.
        run(1'b1, 1'b1, VEC[1], 0, cyc, lb, fb);
        chk(lg_we[lb % 256] == 1'b1, "R9", "first access is write", 32'(lg_we[lb % 256]), 1);
        check_push(VEC[1], cyc, lb);

        // R8: strobes poked in cycle 4 of a return are ignored.
        preload(VEC[1]);
        rv = {40'h0, VEC[1][15:0] - 16'd5};
        run(1'b0, 1'b1, rv, 4, cyc, lb, fb);
        check_pull(VEC[1], cyc, lb, fb);
        lsave = log_n;
        repeat (4) @(negedge clk);
        chk(log_n == lsave, "R8", "no access after return poke", 32'(log_n - lsave), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule